// File: doc/BRIEF.md
# Vector Histogram Bin Counter

This block takes one vector of 8-bit samples and reports how many of its lanes land in a single histogram bin. Every sample is first scaled down by a logical right shift. It is then tested against the bin value, either for an exact match or for being at or below the bin. An optional per-lane predicate can drop lanes from the tally. The surviving match bits are added up by a two-stage reduction tree to give a population count.

The bin index comes either from a scalar input or is forced to zero, which suits the first call of a histogram sweep. Next to the count, the block returns the bin index that follows the one just used, so software can feed it straight into the next call. A new vector can be issued on every cycle. Each result comes out a fixed two cycles after its request and is held until the next result arrives.

Top module: `hist_bin_counter`

## Requirements
- R1: When `bin_from_zero` is 1 the bin used is 0; otherwise it is `bin_in`, zero-extended to 8 bits.
- R2: Lane i is bits [8i+7:8i] of `lane_data`. Before the compare it is logically right-shifted by `scale_shift` (0 to 7).
- R3: With `cmp_le` = 0 a lane matches when its shifted value equals the bin.
- R4: With `cmp_le` = 1 a lane matches when its shifted value is at or below the bin, compared unsigned.
- R5: With `gate_en` = 1 lane i is counted only if `lane_gate[i]` is 1. With `gate_en` = 0, `lane_gate` has no effect on the count.
- R6: `hit_count` equals the number of matching lanes, from 0 up to LANES inclusive.
- R7: `next_bin` equals the bin used plus one, wrapping modulo 2^BIN_W.
- R8: A request sampled with `req_valid` high produces exactly one cycle of `res_valid` two clock edges later. Requests may be issued on back-to-back cycles.
- R9: While reset is held, `res_valid`, `hit_count` and `next_bin` are all 0.
- R10: While `res_valid` is low, `hit_count` and `next_bin` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; the inputs below are sampled with it |
| lane_data | input | LANES*8 | Packed 8-bit samples, lane 0 in the low byte |
| bin_in | input | BIN_W | Scalar bin index |
| scale_shift | input | 3 | Right-shift amount applied to every lane |
| lane_gate | input | LANES | Per-lane predicate |
| cmp_le | input | 1 | 1: at-or-below compare, 0: equality compare |
| gate_en | input | 1 | 1: apply `lane_gate` |
| bin_from_zero | input | 1 | 1: use bin 0 instead of `bin_in` |
| res_valid | output | 1 | Result strobe |
| hit_count | output | $clog2(LANES)+1 | Number of matching lanes |
| next_bin | output | BIN_W | Bin index plus one |

## Verification
Both the count and the next-bin index are due on the second rising edge after the edge that sampled the request. No other result is due in that window. The bench samples each request's inputs on a falling edge and pushes the expected pair into a queue, tagged with the cycle number. A monitor looks at the outputs one time step after every rising edge. When it sees `res_valid`, it pops the oldest entry and checks that exactly two cycles have passed since the push. On every idle cycle it checks that both outputs still hold their last values, so a result that comes early, late or twice does not go unnoticed.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Width of one sample lane in bits.
  localparam int unsigned SAMPLE_W = 8;

  // Width of the scale shift amount.
  localparam int unsigned SHAMT_W  = 3;

  // Compare/gating selection carried through stage 0.
  typedef struct packed {
    logic at_or_below;
    logic gated;
    logic zero_start;
  } hist_mode_t;

endpackage

// File: rtl/hist_lane_cmp.sv
// One lane: scale by right shift, compare with the bin, apply the predicate.
module hist_lane_cmp
  import hist_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W,
  parameter int unsigned SH_W   = SHAMT_W
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] bin_val,
  input  logic              at_or_below,
  input  logic              keep,
  output logic              hit
);

  logic [DATA_W-1:0] scaled;
  logic              eq_hit;
  logic              le_hit;

  always_comb begin
    scaled = sample >> shamt;
    eq_hit = (scaled == bin_val);
    le_hit = (scaled <= bin_val);
    hit    = keep & (at_or_below ? le_hit : eq_hit);
  end

endmodule

// File: rtl/hist_sum_tree.sv
// Balanced binary adder tree over N leaves (N a power of two).
// Node k has children 2k+1 and 2k+2; leaves occupy nodes N-1 .. 2N-2.
module hist_sum_tree #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 1,
  parameter int unsigned OW = 4
) (
  input  logic [N*IW-1:0] leaves,
  output logic [OW-1:0]   total
);

  localparam int unsigned NODES = 2 * N - 1;

  logic [OW-1:0] node [NODES];

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_leaf
      assign node[N-1+gi] = OW'(leaves[gi*IW +: IW]);
    end
    for (gi = 0; gi < N - 1; gi++) begin : g_inner
      assign node[gi] = node[2*gi+1] + node[2*gi+2];
    end
  endgenerate

  assign total = node[0];

endmodule

// File: rtl/hist_bin_counter.sv
// Histogram bin counter: per-lane compare, group partial sums registered,
// group sums reduced and registered. Result two edges after request.
module hist_bin_counter
  import hist_pkg::*;
#(
  parameter int unsigned LANES     = 64,
  parameter int unsigned BIN_W     = 6,
  parameter int unsigned GRP_LANES = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [LANES*SAMPLE_W-1:0]       lane_data,
  input  logic [BIN_W-1:0]                bin_in,
  input  logic [SHAMT_W-1:0]              scale_shift,
  input  logic [LANES-1:0]                lane_gate,
  input  logic                            cmp_le,
  input  logic                            gate_en,
  input  logic                            bin_from_zero,
  output logic                            res_valid,
  output logic [$clog2(LANES):0]          hit_count,
  output logic [BIN_W-1:0]                next_bin
);

  localparam int unsigned CNT_W  = $clog2(LANES) + 1;
  localparam int unsigned NGRP   = LANES / GRP_LANES;
  localparam int unsigned PART_W = $clog2(GRP_LANES) + 1;
  localparam int unsigned PACK_W = NGRP * PART_W;

  // ---------------- stage 0: select bin, compare, group sums ----------------
  hist_mode_t            mode;
  logic [BIN_W-1:0]      cur_bin;
  logic [SAMPLE_W-1:0]   bin_ext;
  logic [LANES-1:0]      keep_vec;
  logic [LANES-1:0]      hit_vec;
  logic [PACK_W-1:0]     part_d;
  logic [BIN_W-1:0]      nbin_d;

  always_comb begin
    mode.at_or_below = cmp_le;
    mode.gated       = gate_en;
    mode.zero_start  = bin_from_zero;
    cur_bin          = mode.zero_start ? '0 : bin_in;
    bin_ext          = SAMPLE_W'(cur_bin);
    keep_vec         = mode.gated ? lane_gate : '1;
    nbin_d           = cur_bin + BIN_W'(1);
  end

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_lane
      hist_lane_cmp #(
        .DATA_W (SAMPLE_W),
        .SH_W   (SHAMT_W)
      ) u_cmp (
        .sample      (lane_data[li*SAMPLE_W +: SAMPLE_W]),
        .shamt       (scale_shift),
        .bin_val     (bin_ext),
        .at_or_below (mode.at_or_below),
        .keep        (keep_vec[li]),
        .hit         (hit_vec[li])
      );
    end
  endgenerate

  genvar gg;
  generate
    for (gg = 0; gg < NGRP; gg++) begin : g_grp
      hist_sum_tree #(
        .N  (GRP_LANES),
        .IW (1),
        .OW (PART_W)
      ) u_part (
        .leaves (hit_vec[gg*GRP_LANES +: GRP_LANES]),
        .total  (part_d[gg*PART_W +: PART_W])
      );
    end
  endgenerate

  // ---------------- stage 1 registers ----------------
  logic              s1_valid_q;
  logic [PACK_W-1:0] s1_part_q;
  logic [BIN_W-1:0]  s1_nbin_q;
  logic              s1_en;

  assign s1_en = req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_part_q <= '0;
      s1_nbin_q <= '0;
    end else if (s1_en) begin
      s1_part_q <= part_d;
      s1_nbin_q <= nbin_d;
    end
  end

  // ---------------- stage 2: reduce group sums ----------------
  logic [CNT_W-1:0] total_d;

  hist_sum_tree #(
    .N  (NGRP),
    .IW (PART_W),
    .OW (CNT_W)
  ) u_final (
    .leaves (s1_part_q),
    .total  (total_d)
  );

  logic              out_valid_q;
  logic [CNT_W-1:0]  count_q;
  logic [BIN_W-1:0]  nbin_q;
  logic              s2_en;

  assign s2_en = s1_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= s1_valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      nbin_q  <= '0;
    end else if (s2_en) begin
      count_q <= total_d;
      nbin_q  <= s1_nbin_q;
    end
  end

  assign res_valid = out_valid_q;
  assign hit_count = count_q;
  assign next_bin  = nbin_q;

endmodule

// File: rtl/hist_bin_counter_chk.sv
module hist_bin_counter_chk
  import hist_pkg::*;
#(
  parameter int unsigned LANES = 64,
  parameter int unsigned BIN_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [LANES*SAMPLE_W-1:0]  lane_data,
  input logic [BIN_W-1:0]           bin_in,
  input logic [SHAMT_W-1:0]         scale_shift,
  input logic [LANES-1:0]           lane_gate,
  input logic                       cmp_le,
  input logic                       gate_en,
  input logic                       bin_from_zero,
  input logic                       res_valid,
  input logic [$clog2(LANES):0]     hit_count,
  input logic [BIN_W-1:0]           next_bin
);

  localparam int unsigned CNT_W = $clog2(LANES) + 1;

  // R8
  req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 res_valid);

  // R8
  res_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid, 2));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (hit_count <= CNT_W'(LANES)));

  // R7
  zero_start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(bin_from_zero, 2)) |-> (next_bin == BIN_W'(1)));

  // R5
  gate_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(gate_en, 2) && ($past(lane_gate, 2) == '0))
      |-> (hit_count == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(hit_count) && $stable(next_bin)));

endmodule

bind hist_bin_counter hist_bin_counter_chk #(
  .LANES (LANES),
  .BIN_W (BIN_W)
) u_hist_chk (.*);

// File: tb/test_hist_bin_counter.sv
module test_hist_bin_counter;

  localparam int LANES = 64;
  localparam int BIN_W = 6;
  localparam int CNT_W = $clog2(LANES) + 1;

  logic                  clk;
  logic                  rst_n;
  logic                  req_valid;
  logic [LANES*8-1:0]    lane_data;
  logic [BIN_W-1:0]      bin_in;
  logic [2:0]            scale_shift;
  logic [LANES-1:0]      lane_gate;
  logic                  cmp_le;
  logic                  gate_en;
  logic                  bin_from_zero;
  logic                  res_valid;
  logic [CNT_W-1:0]      hit_count;
  logic [BIN_W-1:0]      next_bin;

  hist_bin_counter #(.LANES(LANES), .BIN_W(BIN_W)) i_hist_bin_counter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lane_data(lane_data),
    .bin_in(bin_in), .scale_shift(scale_shift), .lane_gate(lane_gate),
    .cmp_le(cmp_le), .gate_en(gate_en), .bin_from_zero(bin_from_zero),
    .res_valid(res_valid), .hit_count(hit_count), .next_bin(next_bin)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    cnt;
    int    nb;
    int    at;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_count(logic [LANES*8-1:0] d, int bin, int sh,
                                     bit le, bit gated, logic [LANES-1:0] g);
    int n = 0;
    for (int i = 0; i < LANES; i++) begin
      int v;
      bit hit;
      v   = int'(d[i*8 +: 8]) >> sh;
      hit = le ? (v <= bin) : (v == bin);
      if (gated && !g[i]) hit = 0;
      if (hit) n++;
    end
    return n;
  endfunction

  task automatic drive(string tag, logic [LANES*8-1:0] d, int b, int sh,
                       bit le, bit gated, bit zs, logic [LANES-1:0] g);
    exp_t e;
    int   bin_used;
    @(negedge clk);
    req_valid     = 1'b1;
    lane_data     = d;
    bin_in        = BIN_W'(b);
    scale_shift   = 3'(sh);
    cmp_le        = le;
    gate_en       = gated;
    bin_from_zero = zs;
    lane_gate     = g;
    bin_used      = zs ? 0 : (b % (1 << BIN_W));
    e.cnt = model_count(d, bin_used, sh, le, gated, g);
    e.nb  = (bin_used + 1) % (1 << BIN_W);
    e.at  = cyc;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      lane_data = '1;
      lane_gate = '0;
    end
  endtask

  function automatic logic [LANES*8-1:0] rnd_vec();
    logic [LANES*8-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  function automatic logic [LANES*8-1:0] fill_vec(logic [7:0] b);
    logic [LANES*8-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*8 +: 8] = b;
    return v;
  endfunction

  // Monitor: one step after each rising edge.
  int last_cnt = 0;
  int last_nb  = 0;
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (res_valid) begin
        if (sb_q.size() == 0) begin
          check("R8 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.tag, " latency"}, cyc - e.at, 2);     // R8
          check({e.tag, " count"}, int'(hit_count), e.cnt);
          check({e.tag, " next_bin R7"}, int'(next_bin), e.nb);
        end
        last_cnt = int'(hit_count);
        last_nb  = int'(next_bin);
      end else begin
        check("R10 count hold", int'(hit_count), last_cnt);
        check("R10 next_bin hold", int'(next_bin), last_nb);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LANES*8-1:0] v;
    logic [LANES-1:0]   g;
    rst_n = 1'b0; req_valid = 1'b0; lane_data = '0; bin_in = '0;
    scale_shift = '0; lane_gate = '0; cmp_le = 1'b0; gate_en = 1'b0;
    bin_from_zero = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 res_valid in reset", int'(res_valid), 0);
    check("R9 hit_count in reset", int'(hit_count), 0);
    check("R9 next_bin in reset", int'(next_bin), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;

    // R3 / R6: every lane equal to the bin gives the full lane count
    drive("R3 all equal", fill_vec(8'd5), 5, 0, 0, 0, 0, '0);
    idle(3);
    // R6: no lane matches
    drive("R6 none", fill_vec(8'd0), 63, 0, 0, 0, 0, '0);
    idle(2);
    // R2 with R3: shifted equality
    v = rnd_vec();
    drive("R2 shift4 eq", v, 3, 4, 0, 0, 0, '0);
    drive("R2 shift7 eq", v, 1, 7, 0, 0, 0, '0);
    idle(2);
    // R4: unsigned at-or-below compare
    drive("R4 le shift2", rnd_vec(), 30, 2, 1, 0, 0, '0);
    drive("R4 le high samples", fill_vec(8'hF0), 59, 2, 1, 0, 0, '0);
    idle(2);
    // R1: zero start ignores bin_in
    drive("R1 zero start", rnd_vec(), 45, 7, 0, 0, 1, '0);
    drive("R1 scalar bin", fill_vec(8'd45), 45, 0, 0, 0, 0, '0);
    idle(2);
    // R5: gated vs ungated with the same gate pattern
    v = rnd_vec();
    g = {$urandom, $urandom};
    drive("R5 gated", v, 20, 3, 1, 1, 0, g);
    drive("R5 gate ignored", v, 20, 3, 1, 0, 0, g);
    drive("R5 gate all off", fill_vec(8'd0), 0, 0, 0, 1, 0, '0);
    idle(2);
    // R7: wrap of next bin
    drive("R7 wrap", rnd_vec(), 63, 2, 1, 0, 0, '0);
    idle(2);
    // R8: back-to-back stream
    for (int k = 0; k < 24; k++) begin
      drive("R8 stream", rnd_vec(), int'($urandom % 64), int'($urandom % 8),
            bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
            {$urandom, $urandom});
    end
    idle(6);
    check("R8 all results seen", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule